// File: doc/BRIEF.md
# Prescaled Timer/Counter Channel

This block is one 16-bit timer/counter channel. A down counter steps once per tick. A tick is either a pulse from an 8-bit reloadable prescaler running on the system clock, or a qualifying edge on one of two external input pins. The edge can be rising, falling or either. When the counter steps from 1 to 0, the block emits a one-cycle terminal-count pulse and toggles an output level. That level is routed to one of two output pins, with optional inversion.

After a terminal count the channel does one of two things, depending on its mode. In continuous mode it reloads from its reload register. In one-shot mode it stops by clearing its own enable.

Software reaches five 16-bit registers over a single-cycle bus. Writes take effect at the next clock edge. Reads are combinational from the address, so no access ever waits.

Top module: `prescaled_timer`

## Requirements
- R1: Control register (address 0) fields: bit 0 enable, bit 1 input-pin select, bits 3:2 tick source (00 prescaler, 01 rising edge, 10 falling edge, 11 either edge), bit 4 output-pin select, bit 5 output invert, bits 7:6 mode (01 one-shot, any other value continuous). Bits 15:8 read as zero and writes to them have no effect.
- R2: A write to the reload register (address 1) while enable is clear also loads the counter. While enable is set, the same write leaves the counter unchanged.
- R3: With the prescaler as tick source, the counter steps once every P+1 enabled cycles, where P is bits 7:0 of the prescale register (address 3, bits 15:8 read zero). While disabled, the prescaler holds at P. A new P written while running takes effect at the next prescaler expiry.
- R4: With an edge tick source, each qualifying edge of the selected pin steps the counter by one, after a two-flop synchroniser. The other pin has no effect.
- R5: A step from 1 to 0 drives `tcPulse` high for one cycle and toggles the output level at the same clock edge.
- R6: In continuous mode, the step that would reach 0 loads the reload value instead, so the counter never rests at 0.
- R7: In one-shot mode the counter stays at 0 and enable clears. A bus write to the control register in that same cycle takes priority.
- R8: The selected output pin shows the output level XOR invert. The unselected pin stays low.
- R9: Status register (address 4) bit 0 is a sticky terminal-count flag. Writing 1 to it clears the flag, and a terminal count in the same cycle wins over the clear.
- R10: A tick while the counter is 0 wraps it to 16'hFFFF and raises no terminal count.
- R11: Reads return address 2 as the live counter value and addresses 5 to 7 as zero. Writes to address 2 are ignored.
- R12: After reset, all registers, the counter, the output level and both output pins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data for busAddr |
| inPin | input | 2 | External event inputs |
| outPin | output | 2 | Output pins |
| tcPulse | output | 1 | One-cycle terminal-count pulse |

## Verification
Counter corruption can be read directly at address 2 in the cycle after it happens. A prescaler phase error shows as a `tcPulse` that arrives early or late within P+1 cycles. A missed or doubled edge shifts the next terminal count by one tick. A wrong output level or routing is visible on `outPin` the cycle after the terminal count. A lost one-shot stop shows as further counting and a set enable bit at address 0. The bench therefore compares the pins and the addressed read data with a behavioural model on every cycle, so any divergence is caught within a cycle of reaching a port.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRESC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  localparam logic [1:0] SRC_PRESC = 2'b00;
  localparam logic [1:0] SRC_RISE  = 2'b01;
  localparam logic [1:0] SRC_FALL  = 2'b10;
  localparam logic [1:0] SRC_BOTH  = 2'b11;
  localparam logic [1:0] MODE_ONESHOT = 2'b01;

  typedef struct packed {
    logic             ce;
    logic             inSel;
    logic [1:0]       srcSel;
    logic             outSel;
    logic             outInv;
    logic             oneShot;
    logic             loadCnt;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] reloadVal;
    logic [PRE_W-1:0] presLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              tcNow,
  input  logic [CNT_W-1:0]  cntVal,
  output ctlStrobe_t        ctl,
  output logic [CNT_W-1:0]  busRdata
);
  localparam int CTL_USED = 8;

  logic             ceR, inSelR, outSelR, invR, stickyR;
  logic [1:0]       srcR, modeR;
  logic [CNT_W-1:0] reloadR;
  logic [PRE_W-1:0] presR;
  logic             wrCtl, wrReload, wrPresc, wrStatus, oneShot;

  assign wrCtl    = busWe && (busAddr == A_CTRL);
  assign wrReload = busWe && (busAddr == A_RELOAD);
  assign wrPresc  = busWe && (busAddr == A_PRESC);
  assign wrStatus = busWe && (busAddr == A_STATUS);
  assign oneShot  = (modeR == MODE_ONESHOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceR <= 1'b0; inSelR <= 1'b0; srcR <= '0; outSelR <= 1'b0;
      invR <= 1'b0; modeR <= '0; reloadR <= '0; presR <= '0; stickyR <= 1'b0;
    end else begin
      if (wrCtl) begin
        ceR     <= busWdata[0];
        inSelR  <= busWdata[1];
        srcR    <= busWdata[3:2];
        outSelR <= busWdata[4];
        invR    <= busWdata[5];
        modeR   <= busWdata[7:6];
      end else if (tcNow && oneShot) begin
        ceR <= 1'b0;
      end
      if (wrReload) reloadR <= busWdata;
      if (wrPresc)  presR   <= busWdata[PRE_W-1:0];
      if (tcNow)                        stickyR <= 1'b1;
      else if (wrStatus && busWdata[0]) stickyR <= 1'b0;
    end
  end

  always_comb begin
    ctl.ce        = ceR;
    ctl.inSel     = inSelR;
    ctl.srcSel    = srcR;
    ctl.outSel    = outSelR;
    ctl.outInv    = invR;
    ctl.oneShot   = oneShot;
    ctl.loadCnt   = wrReload && !ceR;
    ctl.loadVal   = busWdata;
    ctl.reloadVal = reloadR;
    ctl.presLoad  = presR;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL:   busRdata[CTL_USED-1:0] = {modeR, invR, outSelR, srcR, inSelR, ceR};
      A_RELOAD: busRdata = reloadR;
      A_COUNT:  busRdata = cntVal;
      A_PRESC:  busRdata[PRE_W-1:0] = presR;
      A_STATUS: busRdata[0] = stickyR;
      default:  busRdata = '0;
    endcase
  end

  assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tcNow && oneShot && !wrCtl) |=> !ceR);
  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    tcNow |=> stickyR);
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int NPINS = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [NPINS-1:0] inPin,
  output logic             tcNow,
  output logic [CNT_W-1:0] cntVal,
  output logic             tcPulse,
  output logic [NPINS-1:0] outPin
);
  logic [NPINS-1:0] syncA, syncB, prevB;
  logic [PRE_W-1:0] presCnt;
  logic [CNT_W-1:0] cntR;
  logic             outLvl, selCur, selPrev, extEdge, presTick, tick;

  for (genvar i = 0; i < NPINS; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= 1'b0; syncB[i] <= 1'b0; prevB[i] <= 1'b0;
      end else begin
        syncA[i] <= inPin[i]; syncB[i] <= syncA[i]; prevB[i] <= syncB[i];
      end
    end
    assign outPin[i] = (ctl.outSel == 1'(i)) ? (outLvl ^ ctl.outInv) : 1'b0;
  end

  assign selCur  = syncB[ctl.inSel];
  assign selPrev = prevB[ctl.inSel];

  always_comb begin
    case (ctl.srcSel)
      SRC_RISE: extEdge = selCur & ~selPrev;
      SRC_FALL: extEdge = ~selCur & selPrev;
      SRC_BOTH: extEdge = selCur ^ selPrev;
      default:  extEdge = 1'b0;
    endcase
  end

  assign presTick = (presCnt == '0);
  assign tick     = ctl.ce && ((ctl.srcSel == SRC_PRESC) ? presTick : extEdge);
  assign tcNow    = tick && (cntR == CNT_W'(1));
  assign cntVal   = cntR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0; cntR <= '0; tcPulse <= 1'b0; outLvl <= 1'b0;
    end else begin
      if (!ctl.ce)                      presCnt <= ctl.presLoad;
      else if (ctl.srcSel == SRC_PRESC) presCnt <= presTick ? ctl.presLoad : presCnt - 1'b1;
      if (ctl.loadCnt)   cntR <= ctl.loadVal;
      else if (tcNow)    cntR <= ctl.oneShot ? '0 : ctl.reloadVal;
      else if (tick)     cntR <= cntR - 1'b1;
      tcPulse <= tcNow;
      outLvl  <= outLvl ^ tcNow;
    end
  end

  assert_reload_on_tc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tcNow && !ctl.oneShot) |=> (cntR == $past(ctl.reloadVal)));
  assert_wrap_no_tc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntR == '0) |=> (cntR == '1 && !tcPulse));
  assert_level_toggles_R5: assert property (@(posedge clk) disable iff (!rstN)
    tcNow |=> (outLvl != $past(outLvl)));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [1:0]        inPin,
  output logic [1:0]        outPin,
  output logic              tcPulse
);
  ctlStrobe_t       ctl;
  logic             tcNow;
  logic [CNT_W-1:0] cntVal;

  ptmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .tcNow(tcNow), .cntVal(cntVal), .ctl(ctl), .busRdata(busRdata)
  );

  ptmr_datapath #(.NPINS(2)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inPin(inPin), .tcNow(tcNow),
    .cntVal(cntVal), .tcPulse(tcPulse), .outPin(outPin)
  );

  assert_one_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outPin));
endmodule

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;
  logic        clk = 1'b0, rstN = 1'b0, busWe = 1'b0;
  logic [2:0]  busAddr = 3'd2;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [1:0]  inPin = 2'b00;
  logic [1:0]  outPin;
  logic        tcPulse;
  int chkTotal = 0, chkFail = 0;
  bit done = 0;

  prescaled_timer u_dut (.clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .inPin(inPin), .outPin(outPin), .tcPulse(tcPulse));

  always #2 clk = ~clk;

  // behavioural reference state
  logic        mCe, mInSel, mOutSel, mInv, mSticky, mLvl, mTc;
  logic [1:0]  mSrc, mMode, mS1, mS2, mPv;
  logic [15:0] mReload, mCnt;
  logic [7:0]  mPre, mPresCnt;
  logic        tk, tcn, cur, prv, edgeHit;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    chkTotal++;
    if (act !== exp) begin
      chkFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      {mCe, mInSel, mOutSel, mInv, mSticky, mLvl, mTc} = '0;
      {mSrc, mMode, mS1, mS2, mPv} = '0;
      mReload = '0; mCnt = '0; mPre = '0; mPresCnt = '0;
    end else begin
      cur = mS2[mInSel]; prv = mPv[mInSel];
      case (mSrc)
        2'b01: edgeHit = cur && !prv;
        2'b10: edgeHit = !cur && prv;
        2'b11: edgeHit = cur != prv;
        default: edgeHit = 0;
      endcase
      tk  = mCe && (mSrc == 2'b00 ? mPresCnt == 0 : edgeHit);
      tcn = tk && mCnt == 1;
      if (!mCe) mPresCnt = mPre;
      else if (mSrc == 2'b00) mPresCnt = (mPresCnt == 0) ? mPre : mPresCnt - 8'd1;
      if (busWe && busAddr == 1 && !mCe) mCnt = busWdata;
      else if (tcn) mCnt = (mMode == 2'b01) ? 16'd0 : mReload;
      else if (tk) mCnt = mCnt - 16'd1;
      if (busWe && busAddr == 0) begin
        mCe = busWdata[0]; mInSel = busWdata[1]; mSrc = busWdata[3:2];
        mOutSel = busWdata[4]; mInv = busWdata[5]; mMode = busWdata[7:6];
      end else if (tcn && mMode == 2'b01) mCe = 0;
      if (busWe && busAddr == 1) mReload = busWdata;
      if (busWe && busAddr == 3) mPre = busWdata[7:0];
      if (tcn) mSticky = 1;
      else if (busWe && busAddr == 4 && busWdata[0]) mSticky = 0;
      mLvl = mLvl ^ tcn; mTc = tcn;
      mPv = mS2; mS2 = mS1; mS1 = inPin;
    end
  end

  function automatic logic [15:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, mMode, mInv, mOutSel, mSrc, mInSel, mCe};
      3'd1: return mReload;
      3'd2: return mCnt;
      3'd3: return {8'h00, mPre};
      3'd4: return {15'h0, mSticky};
      default: return 16'h0;
    endcase
  endfunction

  always @(negedge clk) if (rstN && !done) begin
    logic [1:0] eo;
    eo = mOutSel ? {mLvl ^ mInv, 1'b0} : {1'b0, mLvl ^ mInv};
    check("R5 tcPulse", {15'h0, tcPulse}, {15'h0, mTc});
    check("R8 outPin", {14'h0, outPin}, {14'h0, eo});
    check(busAddr == 2 ? "R2/R3/R4/R6 count" : "R11 read", busRdata, expRd(busAddr));
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1; busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1; busWe = 0; busAddr = 3'd2;
  endtask
  task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] e);
    @(posedge clk); #1; busAddr = a;
    @(negedge clk); check(tag, busRdata, e);
    @(posedge clk); #1; busAddr = 3'd2;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask
  task automatic toggle(input int pin, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; inPin[pin] = ~inPin[pin];
      idle(3);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1; chkTotal++; chkFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", chkTotal - chkFail, chkTotal);
      $finish;
    end
  end

  initial begin
    idle(3); #1; rstN = 1;
    @(negedge clk);
    check("R12 outPin reset", {14'h0, outPin}, 16'h0);
    check("R12 tcPulse reset", {15'h0, tcPulse}, 16'h0);
    for (int a = 0; a < 8; a++) rd("R12 reset read", 3'(a), 16'h0);
    wr(0, 16'hFF00); rd("R1 upper bits zero", 0, 16'h0000);
    wr(2, 16'h1234); rd("R11 count write ignored", 2, 16'h0000);
    wr(1, 16'd5); rd("R2 load while stopped", 2, 16'd5);
    wr(3, 16'hAB01); rd("R3 prescale upper zero", 3, 16'h0001);
    wr(0, 16'h0001); idle(30);
    wr(1, 16'd3); idle(25);
    wr(3, 16'd0); idle(20);
    wr(0, 16'h0000); wr(4, 16'h0001); rd("R9 sticky cleared", 4, 16'h0);
    wr(1, 16'd4); wr(3, 16'd2); wr(0, 16'h0071); idle(25);
    rd("R7 one-shot cleared enable", 0, 16'h0070);
    rd("R7 one-shot holds zero", 2, 16'h0000);
    rd("R9 sticky set", 4, 16'h0001);
    wr(3, 16'd0); wr(1, 16'd0); wr(0, 16'h0001); idle(3); wr(0, 16'h0000);
    wr(1, 16'd3); wr(0, 16'h0007); toggle(1, 8); toggle(0, 6); idle(4);
    wr(0, 16'h0000); wr(1, 16'd2); wr(0, 16'h002B); toggle(1, 6); idle(4);
    wr(0, 16'h0000); wr(1, 16'd3); wr(0, 16'h001D); toggle(0, 8); toggle(1, 4); idle(4);
    wr(0, 16'h0000); wr(1, 16'd1); wr(3, 16'd0); wr(0, 16'h0001); idle(6);
    wr(4, 16'h0001); idle(3);
    wr(0, 16'h0000); idle(2);
    done = 1;
    $display("%0d/%0d checks passed", chkTotal - chkFail, chkTotal);
    $finish;
  end
endmodule